// File: doc/BRIEF.md
# Power State and Wake Sequencer

This block keeps track of whether a small system-on-chip is running, idling with the CPU clock stopped, or in standby with its clocks possibly stopped. It also controls how the chip comes back out of each state. Software asks to enter idle or standby through two request inputs. A wake interrupt line brings the chip back. The interrupt passes through a two-flop synchronizer before the state machine sees it.

The way back from standby depends on the clock source and two configuration bits. The delay can be a long oscillator-settle countdown, a short fast-wake countdown, or a restart of a few core cycles that matches the exit from idle. The countdowns use a slow timebase tick (16.384 kHz in the target system). Standby also has effects outside the core. While the chip is in standby or settling out of it, the run indicator is low, the external address and data buses are forced to zero, and the peripherals are held in reset.

Top module: `pwr_state_ctrl`

## Requirements
- R1: After reset the block is in the run state: cpu_clk_en_o=1, pll_en_o=1, run_o=1, bus_low_o=0, periph_rst_o=0.
- R2: A high idle_req_i sampled in the run state gives cpu_clk_en_o=0 after that edge, while run_o and pll_en_o stay 1.
- R3: Leaving idle: cpu_clk_en_o goes high at the fifth rising edge, counting as edge 1 the first edge that samples wake_irq_i high. That is two synchronizer edges, one edge to act on the wake, and a two-cycle clock restart.
- R4: In standby and during a settle countdown out of it, run_o=0, bus_low_o=1, periph_rst_o=1 and cpu_clk_en_o=0.
- R5: With pll_src_i=1, pll_en_o is 0 throughout standby and returns to 1 once the settle countdown starts. With pll_src_i=0, pll_en_o stays 1 in standby.
- R6: With pll_src_i=1 and fast_wake_i=0, the standby exit waits for LONG_TICKS tick pulses after the countdown is loaded. LONG_TICKS is 2050 by default, which is 2049 to 2050 tick periods.
- R7: With pll_src_i=1 and fast_wake_i=1, the standby exit waits for SHORT_TICKS tick pulses. SHORT_TICKS is 6 by default, which is 5 to 6 tick periods.
- R8: With pll_src_i=0 and clk_keep_i=0, the standby exit uses the long countdown whatever the value of fast_wake_i.
- R9: With pll_src_i=0 and clk_keep_i=1, the standby exit uses the idle restart path and has the exact R3 timing.
- R10: A new wake pulse during a settle countdown does not reload the countdown.
- R11: idle_req_i and stby_req_i have no effect outside the run state. A request pulse during a wake sequence leaves the block in the run state once the sequence ends.
- R12: When idle_req_i and stby_req_i are both high in the run state, standby is entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idle_req_i | input | 1 | Request to enter idle |
| stby_req_i | input | 1 | Request to enter standby |
| wake_irq_i | input | 1 | Asynchronous wake interrupt |
| fast_wake_i | input | 1 | Select the short settle countdown when on the PLL |
| clk_keep_i | input | 1 | External clock keeps running in standby |
| pll_src_i | input | 1 | Core clock comes from the internal PLL |
| tick_i | input | 1 | One-cycle pulse from the slow timebase |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| pll_en_o | output | 1 | PLL enable |
| run_o | output | 1 | High unless in standby or settling |
| bus_low_o | output | 1 | Force external address/data buses to zero |
| periph_rst_o | output | 1 | Hold peripherals in reset |

## Verification
The assertions assume that tick_i is a single-cycle pulse and that the configuration inputs do not change while a standby exit is deciding its path. The bench meets both conditions. It changes configuration only in the run state and produces the tick from its own counter with a fixed period. For the countdown exits, the bench does not expect an exact cycle, because the tick phase at the wake event is unknown. It measures the time from wake to the return of the CPU clock and checks it against a window derived from the tick count and period. The idle-like exits are checked to the exact cycle.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
   typedef enum logic [2:0] {
      PS_RUN     = 3'd0,
      PS_IDLE    = 3'd1,
      PS_STBY    = 3'd2,
      PS_SETTLE  = 3'd3,
      PS_RESTART = 3'd4
   } pwr_state_e;
endpackage

// File: rtl/pwr_wake_sync.sv
module pwr_wake_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic sync_o
);
   if (STAGES < 2) begin : g_bad
      $error("pwr_wake_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= 1'b0;
            else        chain_q[0] <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= 1'b0;
            else        chain_q[i] <= chain_q[i-1];
         end
      end
   end

   assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/pwr_wake_timer.sv
module pwr_wake_timer #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             step_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             done_o
);
   if (CNT_W < 1) begin : g_bad
      $error("pwr_wake_timer: CNT_W must be positive");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         cnt_q <= '0;
      else if (load_i)                    cnt_q <= load_val_i;
      else if (step_i && (cnt_q != '0))   cnt_q <= cnt_q - 1'b1;
   end

   assign cnt_o  = cnt_q;
   assign done_o = (cnt_q == '0);
endmodule

// File: rtl/pwr_out_ctrl.sv
module pwr_out_ctrl
   import pwr_pkg::*;
(
   input  pwr_state_e state_i,
   input  logic       pll_src_i,
   output logic       cpu_clk_en_o,
   output logic       pll_en_o,
   output logic       run_o,
   output logic       bus_low_o,
   output logic       periph_rst_o
);
   logic halted;

   always_comb begin
      halted       = (state_i == PS_STBY) || (state_i == PS_SETTLE);
      cpu_clk_en_o = (state_i == PS_RUN);
      pll_en_o     = !((state_i == PS_STBY) && pll_src_i);
      run_o        = !halted;
      bus_low_o    = halted;
      periph_rst_o = halted;
   end
endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
   import pwr_pkg::*;
#(
   parameter int LONG_TICKS     = 2050,
   parameter int SHORT_TICKS    = 6,
   parameter int RESTART_CYCLES = 2,
   parameter int SYNC_STAGES    = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic idle_req_i,
   input  logic stby_req_i,
   input  logic wake_irq_i,
   input  logic fast_wake_i,
   input  logic clk_keep_i,
   input  logic pll_src_i,
   input  logic tick_i,
   output logic cpu_clk_en_o,
   output logic pll_en_o,
   output logic run_o,
   output logic bus_low_o,
   output logic periph_rst_o
);
   localparam int MAX_LOAD = (LONG_TICKS > RESTART_CYCLES) ? LONG_TICKS : RESTART_CYCLES;
   localparam int CNT_W    = $clog2(MAX_LOAD + 1);

   if (SHORT_TICKS < 1 || LONG_TICKS <= SHORT_TICKS) begin : g_bad_ticks
      $error("pwr_state_ctrl: need 1 <= SHORT_TICKS < LONG_TICKS");
   end
   if (RESTART_CYCLES < 1) begin : g_bad_restart
      $error("pwr_state_ctrl: RESTART_CYCLES must be at least 1");
   end

   pwr_state_e       state_q, state_d;
   logic             wake_s;
   logic             load;
   logic [CNT_W-1:0] load_val;
   logic             step;
   logic [CNT_W-1:0] cnt;
   logic             done;

   pwr_wake_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (wake_irq_i),
      .sync_o  (wake_s)
   );

   pwr_wake_timer #(.CNT_W(CNT_W)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load),
      .load_val_i (load_val),
      .step_i     (step),
      .cnt_o      (cnt),
      .done_o     (done)
   );

   assign step = (state_q == PS_SETTLE) ? tick_i : 1'b1;

   always_comb begin
      state_d  = state_q;
      load     = 1'b0;
      load_val = '0;
      unique case (state_q)
         PS_RUN: begin
            if (stby_req_i)      state_d = PS_STBY;
            else if (idle_req_i) state_d = PS_IDLE;
         end
         PS_IDLE: begin
            if (wake_s) begin
               state_d  = PS_RESTART;
               load     = 1'b1;
               load_val = CNT_W'(RESTART_CYCLES - 1);
            end
         end
         PS_STBY: begin
            if (wake_s) begin
               load = 1'b1;
               if (!pll_src_i && clk_keep_i) begin
                  state_d  = PS_RESTART;
                  load_val = CNT_W'(RESTART_CYCLES - 1);
               end else begin
                  state_d  = PS_SETTLE;
                  load_val = (pll_src_i && fast_wake_i) ? CNT_W'(SHORT_TICKS)
                                                        : CNT_W'(LONG_TICKS);
               end
            end
         end
         PS_SETTLE, PS_RESTART: begin
            if (done) state_d = PS_RUN;
         end
         default: state_d = PS_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= PS_RUN;
      else        state_q <= state_d;
   end

   pwr_out_ctrl u_out (
      .state_i      (state_q),
      .pll_src_i    (pll_src_i),
      .cpu_clk_en_o (cpu_clk_en_o),
      .pll_en_o     (pll_en_o),
      .run_o        (run_o),
      .bus_low_o    (bus_low_o),
      .periph_rst_o (periph_rst_o)
   );
endmodule

// File: rtl/pwr_state_chk.sv
module pwr_state_chk
   import pwr_pkg::*;
#(
   parameter int CNT_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input pwr_state_e       state_q,
   input logic             wake_s,
   input logic [CNT_W-1:0] cnt,
   input logic             pll_src_i,
   input logic             idle_req_i,
   input logic             stby_req_i,
   input logic             cpu_clk_en_o,
   input logic             pll_en_o,
   input logic             run_o,
   input logic             bus_low_o,
   input logic             periph_rst_o
);
   // R4: standby isolates the outside world
   a_r4_stby_isolate: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PS_STBY || state_q == PS_SETTLE) |->
         (!run_o && bus_low_o && periph_rst_o && !cpu_clk_en_o));

   // R5: PLL switched off in standby when it is the clock source
   a_r5_pll_off: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PS_STBY && pll_src_i) |-> !pll_en_o);

   // R3: a synchronized wake in idle starts the restart
   a_r3_idle_wake: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PS_IDLE && wake_s) |=> (state_q == PS_RESTART));

   // R10: the settle countdown never moves upward
   a_r10_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PS_SETTLE && $past(state_q) == PS_SETTLE) |-> (cnt <= $past(cnt)));

   // R11: requests cannot divert a wake sequence
   a_r11_settle_only_run: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PS_SETTLE && (idle_req_i || stby_req_i)) |=>
         (state_q == PS_SETTLE || state_q == PS_RUN));

   // R12: standby wins over idle
   a_r12_stby_priority: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PS_RUN && stby_req_i) |=> (state_q == PS_STBY));
endmodule

bind pwr_state_ctrl pwr_state_chk #(.CNT_W(CNT_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .state_q      (state_q),
   .wake_s       (wake_s),
   .cnt          (cnt),
   .pll_src_i    (pll_src_i),
   .idle_req_i   (idle_req_i),
   .stby_req_i   (stby_req_i),
   .cpu_clk_en_o (cpu_clk_en_o),
   .pll_en_o     (pll_en_o),
   .run_o        (run_o),
   .bus_low_o    (bus_low_o),
   .periph_rst_o (periph_rst_o)
);

// File: tb/sim_pwr_state_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_state_ctrl;
   localparam int LONG_T  = 12;
   localparam int SHORT_T = 3;
   localparam int TICK_P  = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic idle_req = 1'b0, stby_req = 1'b0, wake = 1'b0;
   logic fast_wake = 1'b0, clk_keep = 1'b0, pll_src = 1'b0, tick = 1'b0;
   logic cpu_en, pll_en, run, bus_low, prst;

   int n_tests = 0;
   int n_fail  = 0;
   int tcnt    = 0;
   logic settle_pll;
   logic settle_run;

   always #5 clk = ~clk;

   always @(negedge clk) begin
      tcnt <= (tcnt == TICK_P - 1) ? 0 : tcnt + 1;
      tick <= (tcnt == TICK_P - 1);
   end

   pwr_state_ctrl #(.LONG_TICKS(LONG_T), .SHORT_TICKS(SHORT_T),
                    .RESTART_CYCLES(2), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .idle_req_i(idle_req), .stby_req_i(stby_req),
      .wake_irq_i(wake), .fast_wake_i(fast_wake), .clk_keep_i(clk_keep),
      .pll_src_i(pll_src), .tick_i(tick), .cpu_clk_en_o(cpu_en),
      .pll_en_o(pll_en), .run_o(run), .bus_low_o(bus_low), .periph_rst_o(prst));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Wake and count rising edges until cpu_clk_en is seen high.
   task automatic wake_measure(input int rep_at, input int req_at, output int n);
      n = 0;
      @(negedge clk) wake = 1'b1;
      while (n < 3000) begin
         @(posedge clk);
         n++;
         @(negedge clk);
         if (n == 3) wake = 1'b0;
         if (n == rep_at) wake = 1'b1;
         if (n == rep_at + 3) wake = 1'b0;
         idle_req = (n == req_at);
         stby_req = (n == req_at);
         if (n == 8) begin settle_pll = pll_en; settle_run = run; end
         if (cpu_en) break;
      end
      wake = 1'b0; idle_req = 1'b0; stby_req = 1'b0;
   endtask

   task automatic enter_stby;
      @(negedge clk) stby_req = 1'b1;
      @(negedge clk) stby_req = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic t_reset;
      check(cpu_en == 1 && pll_en == 1 && run == 1, "R1 enables", {cpu_en, pll_en, run}, 7);
      check(bus_low == 0 && prst == 0, "R1 isolation off", {bus_low, prst}, 0);
   endtask

   task automatic t_idle;
      int n;
      @(negedge clk) idle_req = 1'b1;
      @(negedge clk) idle_req = 1'b0;
      check(cpu_en == 0 && run == 1 && pll_en == 1, "R2 idle outputs", {cpu_en, run, pll_en}, 3);
      repeat (5) @(negedge clk);
      wake_measure(0, 0, n);
      check(n == 5, "R3 idle exit edges", n, 5);
   endtask

   task automatic t_pll_long;
      int n;
      pll_src = 1'b1; fast_wake = 1'b0; clk_keep = 1'b0;
      enter_stby();
      check(run == 0 && bus_low == 1 && prst == 1 && cpu_en == 0, "R4 standby isolate",
            {run, bus_low, prst, cpu_en}, 6);
      check(pll_en == 0, "R5 pll off in standby", pll_en, 0);
      wake_measure(0, 0, n);
      check(settle_pll == 1 && settle_run == 0, "R5/R4 settle outputs", {settle_pll, settle_run}, 2);
      check(n >= (LONG_T - 1) * TICK_P && n <= LONG_T * TICK_P + 6, "R6 long delay", n, LONG_T * TICK_P);
   endtask

   task automatic t_pll_short;
      int n;
      pll_src = 1'b1; fast_wake = 1'b1; clk_keep = 1'b0;
      enter_stby();
      wake_measure(0, 0, n);
      check(n >= (SHORT_T - 1) * TICK_P && n <= SHORT_T * TICK_P + 6, "R7 short delay", n, SHORT_T * TICK_P);
   endtask

   task automatic t_ext_long;
      int n;
      pll_src = 1'b0; fast_wake = 1'b1; clk_keep = 1'b0;
      enter_stby();
      check(pll_en == 1, "R5 pll kept on external clock", pll_en, 1);
      wake_measure(0, 0, n);
      check(n >= (LONG_T - 1) * TICK_P && n <= LONG_T * TICK_P + 6, "R8 ext long delay", n, LONG_T * TICK_P);
   endtask

   task automatic t_ext_keep;
      int n;
      pll_src = 1'b0; fast_wake = 1'b0; clk_keep = 1'b1;
      enter_stby();
      check(run == 0 && bus_low == 1, "R4 standby with clock kept", {run, bus_low}, 1);
      wake_measure(0, 0, n);
      check(n == 5, "R9 kept clock exit edges", n, 5);
   endtask

   task automatic t_rewake;
      int n;
      pll_src = 1'b1; fast_wake = 1'b0; clk_keep = 1'b0;
      enter_stby();
      wake_measure((LONG_T - 2) * TICK_P, 0, n);
      check(n >= (LONG_T - 1) * TICK_P && n <= LONG_T * TICK_P + 6, "R10 no reload", n, LONG_T * TICK_P);
   endtask

   task automatic t_req_ignored;
      int n;
      int lost = 0;
      pll_src = 1'b1; fast_wake = 1'b0; clk_keep = 1'b0;
      enter_stby();
      wake_measure(0, 20, n);
      repeat (10) begin
         @(negedge clk);
         if (!cpu_en || !run) lost++;
      end
      check(lost == 0, "R11 requests during settle ignored", lost, 0);
   endtask

   task automatic t_priority;
      int n;
      pll_src = 1'b0; fast_wake = 1'b0; clk_keep = 1'b1;
      @(negedge clk) begin idle_req = 1'b1; stby_req = 1'b1; end
      @(negedge clk) begin idle_req = 1'b0; stby_req = 1'b0; end
      check(run == 0 && bus_low == 1, "R12 standby wins", {run, bus_low}, 1);
      wake_measure(0, 0, n);
      check(cpu_en == 1, "R12 recovered", cpu_en, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_idle();
      t_pll_long();
      t_pll_short();
      t_ext_long();
      t_ext_keep();
      t_rewake();
      t_req_ignored();
      t_priority();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule